// File: doc/BRIEF.md
# Host Handshake Pin Multiplexer

This block sits between an 8-bit port latch and the upper four pins of that port. Each of these pins can serve as an ordinary port bit or as a signal in the handshake with a host processor. The lower four pins always follow the port latch.

Two one-shot commands switch the upper pins into their alternate roles. The flag command makes bit 4 report that the output buffer is full and bit 5 report that the input buffer is free. In that mode the latch bit of each pin acts as an output enable. The DMA command turns bit 6 into a request line. Writing a 1 to that latch bit sets the request. The request is withdrawn by the acknowledged host transfer it asked for. The same command also turns bit 7 into an active-low acknowledge input. While the acknowledge is low, it selects the data buffers in place of the host chip select.

All state is held in registers clocked by `clk` with an asynchronous active-low reset. The host strobes and the commands are single-cycle or level inputs sampled on the rising edge of `clk`.

Top module: `hs_pin_mux`

## Requirements
- R1: While reset is asserted and after it is released, the port latch holds all ones, both modes are off, no request is pending, and `pin_out` is 8'hFF.
- R2: A `port_wr` cycle loads `port_wdata` into the latch. From the following cycle, `pin_out[3:0]` equals the latch bits 3:0 in every mode.
- R3: While flag mode is off, `pin_out[4]` and `pin_out[5]` equal latch bits 4 and 5.
- R4: While flag mode is on, `pin_out[4]` is `obf` when latch bit 4 is 1, and it is 0 when latch bit 4 is 0.
- R5: While flag mode is on, `pin_out[5]` is the inverse of `ibf` when latch bit 5 is 1, and it is 0 when latch bit 5 is 0.
- R6: While DMA mode is on, `pin_out[6]` shows the request. A `port_wr` with `port_wdata[6]`=1 sets the request from the next cycle. Writing 0 to bit 6 leaves it unchanged. While DMA mode is off, `pin_out[6]` is latch bit 6.
- R7: An acknowledged transfer clears the request in the next cycle. That is a cycle in DMA mode with `pin7_in`=0 and `rd_n` or `wr_n` low. In the same cycle this clear wins over a set.
- R8: Every `cmd_dma` pulse clears the request in the next cycle, including a repeat of the command while DMA mode is already on.
- R9: While DMA mode is on, `pin_out[7]` is 1. When `pin7_in` is 0, `buf_sel`=1 and `buf_a0`=0 whatever `cs_n` and `a0` are.
- R10: When DMA mode is off, or when `pin7_in` is 1, `buf_sel` equals the inverse of `cs_n` and `buf_a0` equals `a0`. With DMA mode off, `pin_out[7]` is latch bit 7 and `pin7_in` has no effect.
- R11: A command pulse turns its mode on from the next cycle. A mode stays on until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Load the port latch this cycle |
| port_wdata | input | 8 | Value for the port latch |
| cmd_flags | input | 1 | Enable-flags command pulse |
| cmd_dma | input | 1 | Enable-DMA command pulse |
| ibf | input | 1 | Input buffer full flag |
| obf | input | 1 | Output buffer full flag |
| cs_n | input | 1 | Host chip select, active low |
| a0 | input | 1 | Host command/data select |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| pin7_in | input | 1 | Sampled level of pin 7, acknowledge when low in DMA mode |
| pin_out | output | 8 | Values driven onto the port pins |
| buf_sel | output | 1 | Data buffer select toward the buffer interface |
| buf_a0 | output | 1 | Command/data select toward the buffer interface |

## Verification
The assertions assume that the host strobes, `pin7_in` and the commands are already synchronous to `clk`. They also assume that a strobe held low for several cycles represents repeated transfers, each of which may clear the request. The stimulus changes every input only at the falling edge of the clock. It mixes directed sequences with random traffic, so acknowledges, strobes, request-setting writes and repeated DMA commands fall in the same cycle in all combinations. An acknowledge outside DMA mode is also applied, to show that it is ignored.

// File: rtl/hs_pin_mux.sv
module hs_pin_mux #(
  parameter logic [7:0] LATCH_INIT = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_wr,
  input  logic [7:0] port_wdata,
  input  logic       cmd_flags,
  input  logic       cmd_dma,
  input  logic       ibf,
  input  logic       obf,
  input  logic       cs_n,
  input  logic       a0,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       pin7_in,
  output logic [7:0] pin_out,
  output logic       buf_sel,
  output logic       buf_a0
);

  logic [7:0] latch;
  logic       flags_on;
  logic       dma_on;
  logic       drq;

  logic dack_act;
  logic drq_clr;
  logic drq_set;

  assign dack_act = dma_on & ~pin7_in;
  assign drq_clr  = cmd_dma | (dack_act & (~rd_n | ~wr_n));
  assign drq_set  = dma_on & port_wr & port_wdata[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch    <= LATCH_INIT;
      flags_on <= 1'b0;
      dma_on   <= 1'b0;
      drq      <= 1'b0;
    end else begin
      if (port_wr)   latch    <= port_wdata;
      if (cmd_flags) flags_on <= 1'b1;
      if (cmd_dma)   dma_on   <= 1'b1;
      if (drq_clr)      drq <= 1'b0;
      else if (drq_set) drq <= 1'b1;
    end
  end

  assign pin_out[3:0] = latch[3:0];
  assign pin_out[4]   = flags_on ? (latch[4] & obf)  : latch[4];
  assign pin_out[5]   = flags_on ? (latch[5] & ~ibf) : latch[5];
  assign pin_out[6]   = dma_on   ? drq               : latch[6];
  assign pin_out[7]   = dma_on   ? 1'b1              : latch[7];

  assign buf_sel = dack_act | ~cs_n;
  assign buf_a0  = dack_act ? 1'b0 : a0;

endmodule

// File: rtl/hs_pin_mux_chk.sv
module hs_pin_mux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_wr,
  input logic [7:0] port_wdata,
  input logic       cmd_dma,
  input logic       cs_n,
  input logic       a0,
  input logic       rd_n,
  input logic       wr_n,
  input logic       pin7_in,
  input logic [7:0] pin_out,
  input logic       buf_sel,
  input logic       buf_a0,
  input logic [7:0] latch,
  input logic       flags_on,
  input logic       dma_on,
  input logic       drq
);

  AST_LOW_NIBBLE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    port_wr |=> pin_out[3:0] == $past(port_wdata[3:0])); // R2

  AST_OBF_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_on && !latch[4]) |-> !pin_out[4]); // R4

  AST_IBF_GATED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_on && !latch[5]) |-> !pin_out[5]); // R5

  AST_DRQ_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on && !pin7_in && (!rd_n || !wr_n)) |=> !pin_out[6]); // R7

  AST_DRQ_REARM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dma |=> !drq); // R8

  AST_DACK_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_on && !pin7_in) |-> (buf_sel && !buf_a0)); // R9

  AST_PIN7_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    dma_on |-> pin_out[7]); // R9

  AST_HOST_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_on |-> (buf_sel == !cs_n && buf_a0 == a0)); // R10

  AST_DMA_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dma_on |=> dma_on); // R11

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    flags_on |=> flags_on); // R11

endmodule

bind hs_pin_mux hs_pin_mux_chk u_chk (.*);

// File: tb/sim_hs_pin_mux.sv
`timescale 1ns/1ps
module sim_hs_pin_mux;
  localparam int HALF = 10;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_wr = 0, cmd_flags = 0, cmd_dma = 0, ibf = 0, obf = 0;
  logic cs_n = 1, a0 = 0, rd_n = 1, wr_n = 1, pin7_in = 1;
  logic [7:0] port_wdata = 0;
  logic [7:0] pin_out;
  logic buf_sel, buf_a0;

  int checks = 0;
  int fails = 0;

  hs_pin_mux u0 (.*);

  always #HALF clk = ~clk;

  // behavioural reference state
  logic [7:0] m_latch;
  bit m_flags, m_dma, m_req;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = 8'hFF; m_flags = 0; m_dma = 0; m_req = 0;
    end else begin
      bit ack_xfer, set_req;
      ack_xfer = m_dma && !pin7_in && (!rd_n || !wr_n);
      set_req  = m_dma && port_wr && port_wdata[6];
      if (cmd_dma || ack_xfer) m_req = 0;
      else if (set_req)        m_req = 1;
      if (port_wr)   m_latch = port_wdata;
      if (cmd_flags) m_flags = 1;
      if (cmd_dma)   m_dma = 1;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    bit ack;
    ack = m_dma && !pin7_in;
    if (!rst_n) chk("R1 reset pins", pin_out, 8'hFF);
    chk("R2 low nibble", {4'b0, pin_out[3:0]}, {4'b0, m_latch[3:0]});
    if (m_flags) begin
      chk("R4 obf pin", {7'b0, pin_out[4]}, {7'b0, m_latch[4] & obf});
      chk("R5 ibf pin", {7'b0, pin_out[5]}, {7'b0, m_latch[5] & ~ibf});
    end else
      chk("R3 plain pins 5:4", {6'b0, pin_out[5:4]}, {6'b0, m_latch[5:4]});
    chk("R6 pin6", {7'b0, pin_out[6]}, {7'b0, m_dma ? m_req : m_latch[6]});
    if (m_dma) chk("R9 pin7 released", {7'b0, pin_out[7]}, 8'h01);
    else       chk("R10 pin7 plain", {7'b0, pin_out[7]}, {7'b0, m_latch[7]});
    if (ack) chk("R9 dack select", {6'b0, buf_sel, buf_a0}, 8'h02);
    else     chk("R10 host select", {6'b0, buf_sel, buf_a0}, {6'b0, !cs_n, a0});
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    port_wr = 0; cmd_flags = 0; cmd_dma = 0; rd_n = 1; wr_n = 1;
  endtask

  task automatic wr_port(input logic [7:0] v);
    port_wr = 1; port_wdata = v; cyc();
  endtask

  initial begin
    #(2 * HALF * LIMIT);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) cyc();                 // R1 under reset
    rst_n = 1;
    cyc();                            // R1 after release
    chk("R1 idle pins", pin_out, 8'hFF);
    // R2 R3 plain port patterns
    wr_port(8'h5A); wr_port(8'hA5); wr_port(8'h00); cyc();
    chk("R2 R3 zero latch", pin_out, 8'h00);
    // R10 pin7_in ignored outside DMA
    pin7_in = 0; cs_n = 1; a0 = 1; rd_n = 0; cyc(); cyc();
    chk("R10 ack ignored", {6'b0, buf_sel, buf_a0}, 8'h01);
    pin7_in = 1;
    // R11 R4 R5 flag mode
    cmd_flags = 1; cyc();
    wr_port(8'h30); obf = 1; ibf = 0; cyc();
    chk("R4 R5 flags on", {6'b0, pin_out[5:4]}, 8'h03);
    obf = 0; ibf = 1; cyc();
    chk("R4 R5 flags low", {6'b0, pin_out[5:4]}, 8'h00);
    wr_port(8'h00); obf = 1; ibf = 0; cyc();
    chk("R4 R5 gated off", {6'b0, pin_out[5:4]}, 8'h00);
    // R6 request only in DMA mode
    wr_port(8'h40); cmd_dma = 1; cyc();
    wr_port(8'h00); cyc();
    chk("R6 idle after enable", {7'b0, pin_out[6]}, 8'h00);
    wr_port(8'h40); wr_port(8'h00); cyc();
    chk("R6 request held", {7'b0, pin_out[6]}, 8'h01);
    // R7 acknowledged read clears
    pin7_in = 0; cs_n = 1; rd_n = 0; cyc(); pin7_in = 1; cyc();
    chk("R7 cleared by read", {7'b0, pin_out[6]}, 8'h00);
    // R7 clear beats set
    pin7_in = 0; wr_n = 0; port_wr = 1; port_wdata = 8'h40; cyc(); pin7_in = 1; cyc();
    chk("R7 clear wins", {7'b0, pin_out[6]}, 8'h00);
    // R8 repeat enable clears
    wr_port(8'h40); cmd_dma = 1; cyc(); cyc();
    chk("R8 reenable clears", {7'b0, pin_out[6]}, 8'h00);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      port_wr    = ($urandom_range(0, 3) == 0);
      port_wdata = 8'($urandom);
      cmd_flags  = ($urandom_range(0, 50) == 0);
      cmd_dma    = ($urandom_range(0, 30) == 0);
      ibf = 1'($urandom); obf = 1'($urandom);
      cs_n = 1'($urandom); a0 = 1'($urandom);
      rd_n = ($urandom_range(0, 3) != 0); wr_n = ($urandom_range(0, 3) != 0);
      pin7_in = ($urandom_range(0, 2) != 0);
      if (i == 2000) begin
        rst_n = 0; cyc(); rst_n = 1;
      end
      cyc();
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule